// File: doc/BRIEF.md
# Pipelined Sliced Carry-Lookahead Adder

This block adds two equal-width binary words, such as the redundant sum and carry vectors left by a carry-save reduction, and returns one ordinary binary sum. The full 24-bit addition is not done in one cycle. It is cut into six 4-bit slices. Each slice resolves its own carries in parallel with a lookahead network, and a register follows each slice. So every clock stage only ever sees one 4-bit lookahead, and the critical path stays short.

The carry leaving slice k is captured in a flip-flop and feeds slice k+1 one cycle later. To meet that carry, the upper operand slices are held back by one extra register per slice. The lower result slices are then held forward, so that all sum bits leave together. A one-bit valid flag travels beside the data with the same delay. A new operand pair may enter on every clock. The carry out of the most significant slice is dropped, so the result wraps modulo 2^24.

Top module: `pipelined_cla_adder`

## Requirements
- R1: While reset (rst_n low, asynchronous) is applied, out_valid reads 0 and out_sum reads 0, whatever the inputs carry.
- R2: For every accepted pair, out_sum equals (in_a + in_b) modulo 2^24.
- R3: A pair sampled with in_valid high at rising edge t appears on out_sum with out_valid high after rising edge t+5, so the latency is six edges including the capture edge.
- R4: Pairs offered on consecutive clocks give results on consecutive clocks, in the same order, with no stall.
- R5: out_valid is high exactly in the cycles that correspond, six edges later, to cycles in which in_valid was high. Idle cycles give out_valid low.
- R6: A carry that is born in the lowest bit reaches the top slice correctly, for example 0x7FFFFF + 0x000001 = 0x800000.
- R7: The carry out of bit 23 is discarded: 0xFFFFFF + 0x000001 = 0x000000 and 0xFFFFFF + 0xFFFFFF = 0xFFFFFE.
- R8: Each 4-bit slice (bits 4k+3..4k) produces a sum nibble and a carry-out equal to the 5-bit sum of its two operand nibbles and its carry-in, so carries cross slice boundaries correctly (for example 0x00000F + 0x000001 = 0x000010).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 24 | First addend |
| in_b | input | 24 | Second addend |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | 24 | Sum modulo 2^24 |

## Verification
The bench builds the adder with its default split of six 4-bit slices. With this split a carry has to cross five slice registers, and the operand and result skew lines have every depth from zero to five. Directed values make a carry travel from bit 0 through all six slices and out of the top. Random streams, both back-to-back and with gaps, exercise all skew depths together.

// File: rtl/psla_pkg.sv
package psla_pkg;

  localparam int DEF_SLICE_W    = 4;
  localparam int DEF_NUM_SLICES = 6;
  localparam int MAX_SLICE_W    = 16;

  // Carry into bit position pos of a slice, formed as a flat sum of products
  // of generate and propagate terms (no ripple through earlier carries).
  function automatic logic lookahead_carry(
    input logic [MAX_SLICE_W-1:0] gen,
    input logic [MAX_SLICE_W-1:0] prop,
    input logic                   cin,
    input int                     pos
  );
    logic acc;
    logic term;
    acc = cin;
    for (int m = 0; m < MAX_SLICE_W; m++) begin
      if (m < pos) acc = acc & prop[m];
    end
    for (int j = 0; j < MAX_SLICE_W; j++) begin
      if (j < pos) begin
        term = gen[j];
        for (int m = 0; m < MAX_SLICE_W; m++) begin
          if (m > j && m < pos) term = term & prop[m];
        end
        acc = acc | term;
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/cla_slice.sv
module cla_slice
  import psla_pkg::*;
#(
  parameter int W = DEF_SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [MAX_SLICE_W-1:0] gen_ext;
  logic [MAX_SLICE_W-1:0] prop_ext;
  logic [W:0]             carries;

  always_comb begin
    gen_ext          = '0;
    prop_ext         = '0;
    gen_ext[W-1:0]   = a & b;
    prop_ext[W-1:0]  = a ^ b;
  end

  for (genvar i = 0; i <= W; i++) begin : g_carry
    assign carries[i] = lookahead_carry(gen_ext, prop_ext, cin, i);
  end

  assign sum  = prop_ext[W-1:0] ^ carries[W-1:0];
  assign cout = carries[W];

endmodule

// File: rtl/skew_line.sv
module skew_line #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/pipelined_cla_adder.sv
module pipelined_cla_adder
  import psla_pkg::*;
#(
  parameter int SLICE_W    = DEF_SLICE_W,
  parameter int NUM_SLICES = DEF_NUM_SLICES,
  localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sum
);

  // Named internal events, brought out for the bound checker.
  logic [DATA_W-1:0]     slice_a_w;
  logic [DATA_W-1:0]     slice_b_w;
  logic [DATA_W-1:0]     slice_sum_w;
  logic [NUM_SLICES-1:0] slice_cin_w;
  logic [NUM_SLICES-1:0] slice_cout_w;
  logic [NUM_SLICES-2:0] link_q;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_stage
    localparam int LO = k * SLICE_W;
    logic [SLICE_W-1:0]   a_d;
    logic [SLICE_W-1:0]   b_d;
    logic [SLICE_W-1:0]   sum_q;

    // operand skew: slice k waits k cycles for its incoming carry
    if (k == 0) begin : g_noskew
      assign a_d = in_a[LO +: SLICE_W];
      assign b_d = in_b[LO +: SLICE_W];
      assign slice_cin_w[k] = 1'b0;
    end else begin : g_skew
      logic [2*SLICE_W-1:0] ab_d;
      skew_line #(.W(2*SLICE_W), .DEPTH(k)) u_opnd (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({in_a[LO +: SLICE_W], in_b[LO +: SLICE_W]}),
        .q     (ab_d)
      );
      assign a_d = ab_d[2*SLICE_W-1:SLICE_W];
      assign b_d = ab_d[SLICE_W-1:0];
      assign slice_cin_w[k] = link_q[k-1];
    end

    assign slice_a_w[LO +: SLICE_W] = a_d;
    assign slice_b_w[LO +: SLICE_W] = b_d;

    cla_slice #(.W(SLICE_W)) u_slice (
      .a    (a_d),
      .b    (b_d),
      .cin  (slice_cin_w[k]),
      .sum  (slice_sum_w[LO +: SLICE_W]),
      .cout (slice_cout_w[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= slice_sum_w[LO +: SLICE_W];
    end

    // carry register between slices; top carry is dropped (wrap)
    if (k < NUM_SLICES - 1) begin : g_link
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link_q[k] <= 1'b0;
        else        link_q[k] <= slice_cout_w[k];
      end
    end

    // result de-skew: lower slices wait for the top slice
    if (k == NUM_SLICES - 1) begin : g_nodeskew
      assign out_sum[LO +: SLICE_W] = sum_q;
    end else begin : g_deskew
      skew_line #(.W(SLICE_W), .DEPTH(NUM_SLICES - 1 - k)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sum_q),
        .q     (out_sum[LO +: SLICE_W])
      );
    end
  end

  skew_line #(.W(1), .DEPTH(NUM_SLICES)) u_valid (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (in_valid),
    .q     (out_valid)
  );

endmodule

// File: rtl/psla_checker.sv
module psla_checker #(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 6,
  localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_sum,
  input logic [DATA_W-1:0] slice_a_w,
  input logic [DATA_W-1:0] slice_b_w,
  input logic [DATA_W-1:0] slice_sum_w,
  input logic [NUM_SLICES-1:0] slice_cin_w,
  input logic [NUM_SLICES-1:0] slice_cout_w
);

  logic              hist_v [NUM_SLICES];
  logic [DATA_W-1:0] hist_s [NUM_SLICES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLICES; i++) begin
        hist_v[i] <= 1'b0;
        hist_s[i] <= '0;
      end
    end else begin
      hist_v[0] <= in_valid;
      hist_s[0] <= in_a + in_b;
      for (int i = 1; i < NUM_SLICES; i++) begin
        hist_v[i] <= hist_v[i-1];
        hist_s[i] <= hist_s[i-1];
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_sum == '0));

  assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist_v[NUM_SLICES-1]);

  assert_sum_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sum == hist_s[NUM_SLICES-1]);

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice_chk
    assert_slice_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
      {slice_cout_w[k], slice_sum_w[k*SLICE_W +: SLICE_W]} ==
        ({1'b0, slice_a_w[k*SLICE_W +: SLICE_W]} +
         {1'b0, slice_b_w[k*SLICE_W +: SLICE_W]} +
         {{SLICE_W{1'b0}}, slice_cin_w[k]}));
  end

endmodule

bind pipelined_cla_adder psla_checker #(
  .SLICE_W    (SLICE_W),
  .NUM_SLICES (NUM_SLICES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_a         (in_a),
  .in_b         (in_b),
  .out_valid    (out_valid),
  .out_sum      (out_sum),
  .slice_a_w    (slice_a_w),
  .slice_b_w    (slice_b_w),
  .slice_sum_w  (slice_sum_w),
  .slice_cin_w  (slice_cin_w),
  .slice_cout_w (slice_cout_w)
);

// File: tb/pipelined_cla_adder_test.sv
`timescale 1ns/1ps
module pipelined_cla_adder_test;

  localparam int DW  = 24;
  localparam int LAT = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic          out_valid;
  logic [DW-1:0] out_sum;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic          hv [LAT];
  logic [DW-1:0] hs [LAT];
  string         ht [LAT];

  always #2 clk = ~clk;

  pipelined_cla_adder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  // reference: plain bit-serial ripple, carry beyond bit 23 thrown away
  function automatic logic [DW-1:0] ref_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] s;
    logic c;
    c = 1'b0;
    for (int i = 0; i < DW; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s out_sum actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  // one clock: check what is due, then drive the next pair
  task automatic step(input logic v, input logic [DW-1:0] a, input logic [DW-1:0] b, input string tag);
    @(negedge clk);
    check_bit({ht[LAT-1], "_R5"}, out_valid, hv[LAT-1]);
    if (hv[LAT-1]) check_word(ht[LAT-1], out_sum, hs[LAT-1]);
    for (int i = LAT-1; i > 0; i--) begin
      hv[i] = hv[i-1];
      hs[i] = hs[i-1];
      ht[i] = ht[i-1];
    end
    hv[0] = v;
    hs[0] = ref_add(a, b);
    ht[0] = tag;
    in_valid = v;
    in_a     = a;
    in_b     = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, "R5");
  endtask

  initial begin
    for (int i = 0; i < LAT; i++) begin
      hv[i] = 1'b0;
      hs[i] = '0;
      ht[i] = "R1";
    end
    // R1: activity on the inputs during reset must not show
    in_valid = 1'b1;
    in_a = 24'h123456;
    in_b = 24'h654321;
    repeat (8) @(negedge clk);
    check_bit("R1", out_valid, 1'b0);
    check_word("R1", out_sum, '0);
    in_valid = 1'b0;
    in_a = '0;
    in_b = '0;
    rst_n = 1'b1;

    // R3: a lone pair, its result exactly six edges later
    step(1'b1, 24'h000123, 24'h000456, "R3");
    idle(8);
    // R6: carry travels from bit 0 into the top slice
    step(1'b1, 24'h7FFFFF, 24'h000001, "R6");
    step(1'b1, 24'h0FFFFF, 24'h000001, "R6");
    // R7: top carry dropped
    step(1'b1, 24'hFFFFFF, 24'h000001, "R7");
    step(1'b1, 24'hFFFFFF, 24'hFFFFFF, "R7");
    step(1'b1, 24'h800000, 24'h800000, "R7");
    // R8: slice boundary carries
    step(1'b1, 24'h00000F, 24'h000001, "R8");
    step(1'b1, 24'h0000F0, 24'h000010, "R8");
    step(1'b1, 24'h0F0F0F, 24'h010101, "R8");
    step(1'b1, 24'hF0F0F0, 24'h101010, "R8");
    idle(LAT + 1);

    // R4: back-to-back random stream
    for (int i = 0; i < 400; i++) step(1'b1, DW'($urandom), DW'($urandom), "R4");
    // R2/R5: random with gaps
    for (int i = 0; i < 800; i++)
      step(1'(($urandom % 3) != 0), DW'($urandom), DW'($urandom), "R2");
    idle(LAT + 2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule